// File: doc/BRIEF.md
# Loadable Up-Counter with Registered Compare Match

This block is a binary up-counter whose width is set by a parameter. On each rising clock edge it can take a new value from a parallel load port, advance by one, or keep its value. A load wins over the enable: a load strobe sets the count to the load value whether or not counting is enabled. Past the all-ones value the count wraps to zero, and no overflow is signalled.

The block compares the running count with a compare value on every cycle. The result goes into an output register before it leaves the block. The match flag therefore describes the count and compare value that were present one cycle earlier. The register removes the wide equality comparator from any path into downstream logic. A change on the compare value alone, with the count held, also updates the flag. An active-low asynchronous reset clears the count and the flag.

Top module: `lcm_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 and match_o is 0, whatever the other inputs are.
- R2: When load_i is 1 at a rising edge, count_o takes load_val_i after that edge, for en_i at 1 or at 0.
- R3: When en_i is 1 and load_i is 0 at a rising edge, count_o increases by one after that edge.
- R4: When en_i and load_i are both 0 at a rising edge, count_o keeps its value.
- R5: Incrementing from all ones (2^WIDTH-1) gives 0 after the edge, with no other indication.
- R6: After each rising edge, match_o is 1 exactly when cmp_val_i equalled count_o just before that edge. The flag trails the count by one cycle.
- R7: A change on cmp_val_i alone, with the count held, updates match_o at the next edge.
- R8: Reset takes priority over load. A load strobe that is active during reset leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all updates occur on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| load_i | input | 1 | Load strobe; overrides en_i |
| load_val_i | input | WIDTH | Value loaded into the count |
| cmp_val_i | input | WIDTH | Value compared with the count |
| count_o | output | WIDTH | Current count |
| match_o | output | 1 | Registered equality flag, one cycle behind the count |

## Verification
The bench strobes load with enable both high and low. A design that gated load with enable would hold or increment instead of loading. It steps the count across all ones to show the wrap to zero, where a saturating design would stick at all ones. It changes only the compare value while the count is held. A comparator evaluated only on count changes would leave the flag stale, and a combinational flag would appear one cycle early. It asserts reset while load is high, so a design that let load win over reset would show the load value.

// File: rtl/lcm_counter_pkg.sv
package lcm_counter_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/lcm_cnt_ctrl.sv
module lcm_cnt_ctrl
  import lcm_counter_pkg::*;
(
  input  logic    en_i,
  input  logic    load_i,
  output cnt_op_e op_o
);
  // load overrides enable
  always_comb begin
    if (load_i)    op_o = OP_LOAD;
    else if (en_i) op_o = OP_INC;
    else           op_o = OP_HOLD;
  end
endmodule

// File: rtl/lcm_cnt_core.sv
module lcm_cnt_core
  import lcm_counter_pkg::*;
#(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    unique case (op_i)
      OP_LOAD: cnt_d = load_val_i;
      OP_INC:  cnt_d = cnt_q + ONE; // wraps silently
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/lcm_cmp_reg.sv
module lcm_cmp_reg #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             eq_o
);
  logic eq_q;

  // both operands feed the compare every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= (a_i == b_i);
  end

  assign eq_o = eq_q;
endmodule

// File: rtl/lcm_counter.sv
module lcm_counter
  import lcm_counter_pkg::*;
#(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic [WIDTH-1:0] cmp_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             match_o
);
  cnt_op_e          op;
  logic [WIDTH-1:0] cnt;

  lcm_cnt_ctrl u_ctrl (
    .en_i   (en_i),
    .load_i (load_i),
    .op_o   (op)
  );

  lcm_cnt_core #(.WIDTH(WIDTH)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .load_val_i (load_val_i),
    .count_o    (cnt)
  );

  lcm_cmp_reg #(.WIDTH(WIDTH)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (cnt),
    .b_i    (cmp_val_i),
    .eq_o   (match_o)
  );

  assign count_o = cnt;
endmodule

// File: rtl/lcm_counter_chk.sv
module lcm_counter_chk #(
  parameter int unsigned WIDTH = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             load_i,
  input logic [WIDTH-1:0] load_val_i,
  input logic [WIDTH-1:0] cmp_val_i,
  input logic [WIDTH-1:0] count_o,
  input logic             match_o
);
  localparam logic [WIDTH-1:0] ONES = '1;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_o == $past(load_val_i)));

  assert_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> (count_o == WIDTH'($past(count_o) + 1'b1)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(count_o));

  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && count_o == ONES) |=> (count_o == '0));

  assert_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (match_o == ($past(cmp_val_i) == $past(count_o))));

  assert_cmp_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i && cmp_val_i == count_o) |=> match_o);
endmodule

bind lcm_counter lcm_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/lcm_counter_bench.sv
`timescale 1ns/1ps
module lcm_counter_bench;
  localparam int unsigned W = 8;

  typedef struct packed {
    logic        en;
    logic        ld;
    logic [W-1:0] lv;
    logic [W-1:0] cmp;
    logic [W-1:0] exp_cnt;
    logic        exp_m;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'hF0, 8'h00, 8'hF0, 1'b1, 8'd2}, // R2 load, en low
    '{1'b1, 1'b0, 8'h00, 8'hF0, 8'hF1, 1'b1, 8'd3}, // R3 inc, R6 match
    '{1'b1, 1'b0, 8'h00, 8'hF0, 8'hF2, 1'b0, 8'd6}, // R6 lag
    '{1'b0, 1'b0, 8'h55, 8'hF2, 8'hF2, 1'b1, 8'd4}, // R4 hold
    '{1'b0, 1'b0, 8'h55, 8'hF3, 8'hF2, 1'b0, 8'd7}, // R7 cmp only
    '{1'b0, 1'b0, 8'h55, 8'hF2, 8'hF2, 1'b1, 8'd7}, // R7 cmp back
    '{1'b1, 1'b1, 8'hFE, 8'h00, 8'hFE, 1'b0, 8'd2}, // R2 load, en high
    '{1'b1, 1'b0, 8'h00, 8'hFE, 8'hFF, 1'b1, 8'd3}, // R3
    '{1'b1, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b1, 8'd5}, // R5 wrap
    '{1'b1, 1'b0, 8'h00, 8'hFF, 8'h01, 1'b0, 8'd5}, // R5 after wrap
    '{1'b0, 1'b1, 8'h01, 8'h01, 8'h01, 1'b1, 8'd2}, // R2 load same
    '{1'b1, 1'b0, 8'h00, 8'h00, 8'h02, 1'b0, 8'd3}  // R3
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0, ld = 1'b0;
  logic [W-1:0] lv = '0, cmp = '0;
  logic [W-1:0] count;
  logic         match;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lcm_counter #(.WIDTH(W)) u_lcm_counter (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_i(ld),
    .load_val_i(lv), .cmp_val_i(cmp), .count_o(count), .match_o(match)
  );

  task automatic chk(input string tag, input logic [W-1:0] c_exp, input logic m_exp);
    checks++;
    if (count !== c_exp || match !== m_exp) begin
      fails++;
      $display("FAIL %s: count=%h match=%b expected count=%h match=%b",
               tag, count, match, c_exp, m_exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state with stimulus present
    ld = 1'b1; lv = 8'hAA; en = 1'b1; cmp = 8'h00;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset state", 8'h00, 1'b0);
    @(negedge clk);
    ld = 1'b0; en = 1'b0; cmp = 8'h11;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      en = VECS[i].en; ld = VECS[i].ld; lv = VECS[i].lv; cmp = VECS[i].cmp;
      @(posedge clk);
      #1 chk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp_cnt, VECS[i].exp_m);
    end

    // R8: reset beats load, count goes to 0 asynchronously and stays
    @(negedge clk);
    en = 1'b1; ld = 1'b1; lv = 8'h77; cmp = 8'h00;
    rst_n = 1'b0;
    #0.5 chk("R8 async clear", 8'h00, 1'b0);
    @(posedge clk);
    #1 chk("R8 load during reset", 8'h00, 1'b0);
    @(posedge clk);
    #1 chk("R1 reset held", 8'h00, 1'b0);

    // release; first edge: load 0x77, flag from count 0 vs cmp 0
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1 chk("R2 load after reset", 8'h77, 1'b1);

    // R5: load all ones then increment
    @(negedge clk);
    ld = 1'b1; lv = 8'hFF; en = 1'b0; cmp = 8'h12;
    @(posedge clk);
    #1 chk("R2 load ones", 8'hFF, 1'b0);
    @(negedge clk);
    ld = 1'b0; en = 1'b1; cmp = 8'hFF;
    @(posedge clk);
    #1 chk("R5 wrap to zero", 8'h00, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule